// File: doc/BRIEF.md
# Iterative Shift-and-Add Vector Rotator

This block is a CORDIC engine that works one iteration per clock. It has a single datapath with two variable arithmetic right shifters and three adder/subtractors. The datapath is reused for every iteration. Three working registers hold the abscissa, the ordinate and the residual angle. A small arctangent table holds one entry per iteration and the iteration counter indexes it. The parameter `VECTOR` fixes the mode at build time.

- In rotation mode the engine turns the input vector (`x_in`, `y_in`) by the angle `a_in`. It can be used for polar-to-Cartesian conversion or to make sine and cosine.
- In vectoring mode the engine turns the input vector onto the positive x axis. It adds up the angle it turned through, so the outputs give the scaled magnitude and the phase.

A one-cycle `load` strobe captures a new operand set and starts a computation. `done` pulses for one cycle when the results on `x_out`, `y_out` and `a_out` are valid. A new `load` may arrive during a computation, and it then restarts the engine with the new operands. A new `load` may also arrive in the same cycle as `done`. While `clk_en` is low, all state is frozen. Outputs carry the usual CORDIC gain K (about 1.647 for 16 iterations). The block does not correct this gain.

Top module: `cordic_iter`

## Requirements
- R1: `done` rises exactly ITER+1 enabled clock cycles after the cycle in which `load` is sampled high.
- R2: `done` stays high for one enabled clock cycle only.
- R3: With VECTOR=0, the outputs are `x_out` ≈ K·(x·cosθ − y·sinθ) and `y_out` ≈ K·(x·sinθ + y·cosθ), and `a_out` ≈ 0, each within a few LSB. Linear values are two's complement with 1.0 = 2^(W-2). Angles are two's complement with π = 2^(W-1), and |θ| ≤ π/2.
- R4: With VECTOR=1 and x > 0, the outputs are `x_out` ≈ K·√(x²+y²), `y_out` ≈ 0 and `a_out` ≈ a_in + atan2(y, x), using the same number formats as R3.
- R5: A `load` taken while a computation is running discards it. Exactly one `done` follows, ITER+1 cycles after the last `load`, and it carries the new operands' results.
- R6: A `load` in the same cycle as `done` starts the next computation, and the result just presented is still valid in that cycle.
- R7: While `clk_en` is low, the outputs, `done` and the iteration progress all hold. The completion is delayed by exactly the number of disabled cycles.
- R8: Driving `arst_n` low immediately (without a clock) clears `done` and the outputs to zero and abandons any computation. No `done` follows until the next `load`.
- R9: After completion the outputs stay unchanged until the next `load`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| arst_n | input | 1 | Asynchronous reset, active low |
| clk_en | input | 1 | Clock enable; low freezes all state |
| load | input | 1 | Start strobe, captures the operands |
| x_in | input | W | Initial abscissa (1.0 = 2^(W-2)) |
| y_in | input | W | Initial ordinate |
| a_in | input | W | Initial angle (π = 2^(W-1)) |
| x_out | output | W | Final abscissa or scaled magnitude |
| y_out | output | W | Final ordinate |
| a_out | output | W | Residual angle or phase |
| done | output | 1 | One-cycle result-valid pulse |

## Verification
The bench drives a rotation instance and a vectoring instance side by side. It compares their results against floating-point trigonometry, so a wrong sign-decision source or a mis-scaled arctangent entry shows up as a result that is many LSB off.

The bench goes after the following corner cases, and each would break in a visible way:
- Restart: the bench reloads in mid-computation. An engine that ignored the restart would pulse `done` early with stale data.
- Load during `done`: the bench loads in the same cycle as `done`. An engine that dropped that load would never deliver the second result.
- Clock-enable stall: the bench stalls in mid-computation. An engine that kept counting would finish too early.
- Asynchronous reset: the bench resets in mid-computation. An engine that did not abandon the work would emit a spurious `done`.

// File: rtl/cordic_iter.sv
module cordic_iter #(
  parameter int W      = 16,
  parameter int ITER   = 16,
  parameter bit VECTOR = 1'b0
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic         clk_en,
  input  logic         load,
  input  logic [W-1:0] x_in,
  input  logic [W-1:0] y_in,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] x_out,
  output logic [W-1:0] y_out,
  output logic [W-1:0] a_out,
  output logic         done
);
  localparam int CW = $clog2(ITER + 1);
  localparam int IW = (ITER > 1) ? $clog2(ITER) : 1;
  localparam int TD = 1 << IW;

  function automatic logic [W-1:0] atan_q(int i);
    real v;
    v = $atan(2.0 ** (-i)) / 3.141592653589793 * (2.0 ** (W - 1));
    return W'($rtoi(v + 0.5));
  endfunction

  logic signed [W-1:0] rx, ry, ra;
  logic signed [W-1:0] atab [TD];
  logic [CW-1:0]       cnt;
  logic                busy;

  for (genvar g = 0; g < TD; g++) begin : g_tab
    assign atab[g] = atan_q(g);
  end

  logic signed [W-1:0] sx, sy, ang;
  logic                neg;
  assign sx  = rx >>> cnt;
  assign sy  = ry >>> cnt;
  assign ang = atab[cnt[IW-1:0]];
  assign neg = VECTOR ? ~ry[W-1] : ra[W-1];

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rx <= '0; ry <= '0; ra <= '0;
      cnt <= '0; busy <= 1'b0; done <= 1'b0;
    end else if (clk_en) begin
      done <= 1'b0;
      if (load) begin
        rx <= x_in; ry <= y_in; ra <= a_in;
        cnt <= '0; busy <= 1'b1;
      end else if (busy) begin
        rx <= neg ? rx + sy : rx - sy;
        ry <= neg ? ry - sx : ry + sx;
        ra <= neg ? ra + ang : ra - ang;
        cnt <= cnt + 1'b1;
        if (cnt == CW'(ITER - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  assign x_out = rx;
  assign y_out = ry;
  assign a_out = ra;

  p_pulse_r2: assert property (@(posedge clk) disable iff (!arst_n)
    done && clk_en |=> !done);
  p_hold_r7: assert property (@(posedge clk) disable iff (!arst_n)
    !clk_en |=> $stable({x_out, y_out, a_out, done, cnt, busy}));
  p_restart_r5: assert property (@(posedge clk) disable iff (!arst_n)
    load && clk_en |=> busy && !done && cnt == '0);
  p_idle_r9: assert property (@(posedge clk) disable iff (!arst_n)
    !busy && !load |=> $stable({x_out, y_out, a_out}));
  p_finish_r1: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(done) |-> $past(busy) && $past(cnt) == CW'(ITER - 1));
endmodule

// File: tb/sim_cordic_iter.sv
module sim_cordic_iter;
  localparam int W = 16, ITER = 16, TOL = 12;
  localparam real PI = 3.141592653589793;

  typedef struct {
    int  t;
    real rx, ry, mag, ph;
  } exp_t;

  logic clk = 0, arst_n = 0, clk_en = 1, load = 0;
  logic [W-1:0] x_in = '0, y_in = '0, a_in = '0;
  logic [W-1:0] rxo, ryo, rao, vxo, vyo, vao;
  logic rdone, vdone;
  int cyc = 0, checks = 0, errors = 0;
  exp_t q[$];
  real kg;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cordic_iter #(.W(W), .ITER(ITER), .VECTOR(1'b0)) u0 (
    .clk(clk), .arst_n(arst_n), .clk_en(clk_en), .load(load),
    .x_in(x_in), .y_in(y_in), .a_in(a_in),
    .x_out(rxo), .y_out(ryo), .a_out(rao), .done(rdone));
  cordic_iter #(.W(W), .ITER(ITER), .VECTOR(1'b1)) u1 (
    .clk(clk), .arst_n(arst_n), .clk_en(clk_en), .load(load),
    .x_in(x_in), .y_in(y_in), .a_in('0),
    .x_out(vxo), .y_out(vyo), .a_out(vao), .done(vdone));

  task automatic chk(string req, int act, int exp, int tol);
    int d;
    d = act - exp;
    checks++;
    if (d > tol || d < -tol) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int lin(real v); return $rtoi(v * (2.0 ** (W-2)) + (v < 0 ? -0.5 : 0.5)); endfunction
  function automatic int angq(real a); return $rtoi(a / PI * (2.0 ** (W-1)) + (a < 0 ? -0.5 : 0.5)); endfunction
  function automatic int sx(logic [W-1:0] v); return int'(signed'(v)); endfunction

  // driver: call right after a negedge
  task automatic issue(real x, real y, real a, bit replace);
    exp_t e;
    x_in = W'(lin(x)); y_in = W'(lin(y)); a_in = W'(angq(a));
    load = 1;
    e.t   = cyc + ITER + 1;
    e.rx  = kg * (x * $cos(a) - y * $sin(a)) * (2.0 ** (W-2));
    e.ry  = kg * (x * $sin(a) + y * $cos(a)) * (2.0 ** (W-2));
    e.mag = kg * $sqrt(x * x + y * y) * (2.0 ** (W-2));
    e.ph  = $atan2(y, x) / PI * (2.0 ** (W-1));
    if (replace && q.size() > 0) q[$] = e; else q.push_back(e);
    @(negedge clk);
    load = 0;
  endtask

  task automatic wait_done();
    do @(negedge clk); while (!rdone);
  endtask

  // monitor / scoreboard
  bit pd = 0, pce = 1;
  always @(negedge clk) begin
    if (arst_n) begin
      if (rdone && pd && pce) chk("R2 done width", 2, 1, 0);
      if (rdone) begin
        exp_t e;
        if (q.size() == 0) chk("R8/R5 unexpected done", 1, 0, 0);
        else begin
          e = q.pop_front();
          chk("R1 latency", cyc, e.t, 0);
          chk("R5 vector done aligned", int'(vdone), 1, 0);
          chk("R3 rot x", sx(rxo), $rtoi(e.rx), TOL);
          chk("R3 rot y", sx(ryo), $rtoi(e.ry), TOL);
          chk("R3 rot residual angle", sx(rao), 0, TOL);
          chk("R4 vec magnitude", sx(vxo), $rtoi(e.mag), TOL);
          chk("R4 vec y", sx(vyo), 0, TOL);
          chk("R4 vec phase", sx(vao), $rtoi(e.ph), TOL);
        end
      end
    end
    pd = rdone; pce = clk_en;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] hx, hy, ha;
    kg = 1.0;
    for (int i = 0; i < ITER; i++) kg = kg * $sqrt(1.0 + 2.0 ** (-2 * i));
    #3;
    chk("R8 reset done", int'(rdone), 0, 0);
    chk("R8 reset x_out", sx(rxo), 0, 0);
    repeat (3) @(negedge clk);
    arst_n = 1;
    @(negedge clk);
    // R3/R4 patterns
    issue(0.9, 0.0, 0.0, 0);        wait_done();
    @(negedge clk); issue(0.6, 0.2, PI/4, 0);   wait_done();
    @(negedge clk); issue(0.5, -0.3, -PI/3, 0); wait_done();
    @(negedge clk); issue(0.7, 0.4, PI/2, 0);   wait_done();
    @(negedge clk); issue(0.3, -0.6, -PI/2, 0); wait_done();
    // R6: load coinciding with done
    @(negedge clk); issue(0.8, 0.1, 0.5, 0); wait_done();
    issue(0.4, 0.5, -0.9, 0); wait_done();
    // R9: idle outputs hold
    hx = rxo; hy = ryo; ha = rao;
    repeat (10) @(negedge clk);
    chk("R9 idle x", sx(rxo), sx(hx), 0);
    chk("R9 idle y", sx(ryo), sx(hy), 0);
    chk("R9 idle a", sx(rao), sx(ha), 0);
    // R5: restart in mid-computation
    issue(0.9, -0.2, 1.2, 0);
    repeat (4) @(negedge clk);
    issue(0.2, 0.7, -0.4, 1); wait_done();
    // R7: clock-enable stall
    @(negedge clk); issue(0.5, 0.5, 0.3, 0);
    repeat (3) @(negedge clk);
    clk_en = 0; hx = rxo; hy = ryo;
    repeat (5) @(negedge clk);
    chk("R7 stall x hold", sx(rxo), sx(hx), 0);
    chk("R7 stall y hold", sx(ryo), sx(hy), 0);
    chk("R7 stall done low", int'(rdone), 0, 0);
    clk_en = 1; q[$].t += 5;
    wait_done();
    // R8: asynchronous reset in mid-computation
    @(negedge clk); issue(0.6, 0.1, 0.7, 0);
    repeat (3) @(negedge clk);
    #2 arst_n = 0;
    #1;
    chk("R8 async done", int'(rdone), 0, 0);
    chk("R8 async x_out", sx(rxo), 0, 0);
    q.delete();
    @(negedge clk); arst_n = 1;
    repeat (ITER + 6) @(negedge clk);
    chk("R8 no done after reset", int'(rdone), 0, 0);
    chk("R1 queue drained", q.size(), 0, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule